// File: doc/BRIEF.md
# Virtual Address Translation Front End

This block sits between an address generator and a translation buffer. Each cycle it may take one request: a 64-bit virtual address, an access type (read, write or execute) and the current privilege mode. It checks that the address is properly sign-extended and decodes two direct-mapped kernel windows that skip the translation buffer. Any other address goes to the translation buffer through a combinational lookup port, with the page number sent out and hit, frame number and permission bits returned in the same cycle. The result is one registered response per request. It holds either a physical address or a single fault code chosen by a fixed priority.

The fault code tells the requester what to do next. A miss means a page-table walk and a refill. A fault-on-access means the software handling dirty or accessed bits must run. An access violation or a translation-not-valid goes to the operating system. Every response carries an access tag so that the exception logic can tell instruction faults from data read or data write faults. Storing the entries and delivering the exceptions are handled by other blocks.

Top module: `va_xlate_front`

## Requirements
- R1: An address whose bits 63 down to 42 are not all equal gives fault code 1 (bad address), whatever the mode, window enables or translation-buffer reply, and no lookup is requested.
- R2: When `sp_enable[0]` is set and address bits [42:41] equal 2'b10, a kernel request gives `rsp_pa` = address bits [40:0] zero-extended, and `tlb_req` stays low.
- R3: When `sp_enable[1]` is set and address bits [44:32] equal 13'h1FFE, a kernel request gives `rsp_pa` = address bits [31:0] zero-extended, and `tlb_req` stays low.
- R4: A request that falls into an enabled window in a mode other than kernel (mode 0) gives fault code 2 (access violation). Modes are kernel 0, executive 1, supervisor 2, user 3.
- R5: A canonical address outside every enabled window raises `tlb_req` in the request cycle with `tlb_vpn` = address bits [42:13]. If `tlb_hit` is low, the response is fault code 4 (miss).
- R6: On a hit with every required permission present, `rsp_pa` = {`tlb_pfn`, address bits [12:0]}.
- R7: Permission layout: bit 0 valid, bit 1 fault-on-read, bit 2 fault-on-write, bit 3 fault-on-execute, bits [7:4] read enable per mode, bits [11:8] write enable per mode (bit index = base + mode). Read needs read enable, valid and fault-on-read clear. Execute needs read enable, valid and fault-on-execute clear. Write needs write enable, valid and fault-on-write clear. Access codes are read 0, write 1, execute 2, and 3 is handled as read.
- R8: If a required permission is missing on a hit, the fault code is 2 when the mode enable is missing, else 3 (fault-on-access) when the fault-on bit is set, else 5 (not valid).
- R9: `rsp_kind` is 2 for execute, 1 for write and 0 for read (and for access code 3), on every response.
- R10: The response appears in the cycle after the request. `rsp_valid` is low in the cycle after a cycle with no request. Whenever `rsp_valid` is high, exactly one of `rsp_pa_valid` and `rsp_fault` is high. A fault response has `rsp_pa` = 0, and a success has code 0. After reset all response outputs are 0.
- R11: With a window's enable bit clear, an address in that window goes to the translation buffer like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_mode | input | 2 | Current mode: 0 kernel .. 3 user |
| sp_enable | input | 2 | Bit 0: 43-bit window, bit 1: 32-bit window |
| tlb_req | output | 1 | Lookup request to the translation buffer |
| tlb_vpn | output | 30 | Virtual page number for the lookup |
| tlb_hit | input | 1 | Lookup hit |
| tlb_pfn | input | 31 | Frame number of the hit entry |
| tlb_perm | input | 12 | Permission bits of the hit entry |
| rsp_valid | output | 1 | Response present |
| rsp_pa_valid | output | 1 | Translation succeeded |
| rsp_pa | output | 44 | Physical address |
| rsp_fault | output | 1 | Translation faulted |
| rsp_fault_code | output | 3 | 0 none, 1 bad address, 2 access violation, 3 fault-on-access, 4 miss, 5 not valid |
| rsp_kind | output | 2 | Access tag of the response |

## Verification
Every decision is made within a single request, so a wrong internal choice shows up in the very next cycle as a wrong fault code, a wrong physical address or a wrong lookup strobe. No result is deferred to later requests. A wrong window decode shows at once as a lookup request where none belongs, or none where one belongs. A wrong priority shows as the wrong code when two or more permissions are missing at once. That is why the tests present permission sets with several missing bits, and also requests that fall into disabled windows or use non-kernel modes.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;

  localparam int PERM_W = 12;
  localparam int P_V    = 0;
  localparam int P_FOR  = 1;
  localparam int P_FOW  = 2;
  localparam int P_FOE  = 3;
  localparam int P_RE   = 4;
  localparam int P_WE   = 8;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_BVA  = 3'd1,
    FC_ACV  = 3'd2,
    FC_FOX  = 3'd3,
    FC_TBM  = 3'd4,
    FC_TNV  = 3'd5
  } fault_e;

  localparam logic [PERM_W-1:0] FO_BITS = PERM_W'((1 << P_FOR) | (1 << P_FOW) | (1 << P_FOE));
  localparam logic [PERM_W-1:0] MODE_BITS = PERM_W'(12'hFF0);

  // Bits that the access needs to find set in the normalised grant vector.
  function automatic logic [PERM_W-1:0] required_mask(input logic [1:0] mode,
                                                      input logic [1:0] acc);
    logic [PERM_W-1:0] m;
    m = '0;
    m[P_V] = 1'b1;
    case (acc)
      ACC_WR: begin
        m[P_WE + int'(mode)] = 1'b1;
        m[P_FOW] = 1'b1;
      end
      ACC_EX: begin
        m[P_RE + int'(mode)] = 1'b1;
        m[P_FOE] = 1'b1;
      end
      default: begin
        m[P_RE + int'(mode)] = 1'b1;
        m[P_FOR] = 1'b1;
      end
    endcase
    return m;
  endfunction

  // Fault-on bits flipped so that every bit reads as "granted when set".
  function automatic logic [PERM_W-1:0] grant_vector(input logic [PERM_W-1:0] perm);
    return perm ^ FO_BITS;
  endfunction

  // Three-level priority over the missing bits.
  function automatic fault_e classify_missing(input logic [PERM_W-1:0] missing);
    if ((missing & MODE_BITS) != '0) return FC_ACV;
    if ((missing & FO_BITS) != '0)   return FC_FOX;
    if (missing[P_V])                return FC_TNV;
    return FC_NONE;
  endfunction

  function automatic logic [1:0] kind_tag(input logic [1:0] acc);
    if (acc == ACC_EX) return 2'd2;
    if (acc == ACC_WR) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/va_region_decode.sv
module va_region_decode
  import va_xlate_pkg::*;
#(
  parameter int VA_W  = 43,
  parameter int PA_W  = 44,
  parameter int SP_LO = 32
) (
  input  logic [63:0]     va,
  input  logic [1:0]      sp_enable,
  output logic            canonical,
  output logic            sp_large_hit,
  output logic            sp_small_hit,
  output logic [PA_W-1:0] sp_pa
);

  localparam int SEXT_W  = 64 - (VA_W - 1);
  localparam int LARGE_W = VA_W - 2;
  localparam int SMALL_HI = VA_W + 1;
  localparam int SMALL_FW = SMALL_HI - SP_LO + 1;
  localparam logic [SMALL_FW-1:0] SMALL_VAL = {{(SMALL_FW-1){1'b1}}, 1'b0};

  logic [SEXT_W-1:0] sext_field;
  logic              region_large;
  logic              region_small;

  assign sext_field   = va[63:VA_W-1];
  assign canonical    = (&sext_field) | ~(|sext_field);
  assign region_large = (va[VA_W-1:VA_W-2] == 2'b10);
  assign region_small = (va[SMALL_HI:SP_LO] == SMALL_VAL);
  assign sp_large_hit = sp_enable[0] & region_large;
  assign sp_small_hit = sp_enable[1] & region_small;

  always_comb begin
    sp_pa = '0;
    if (sp_large_hit) sp_pa[LARGE_W-1:0] = va[LARGE_W-1:0];
    else if (sp_small_hit) sp_pa[SP_LO-1:0] = va[SP_LO-1:0];
  end

endmodule

// File: rtl/perm_fault_eval.sv
module perm_fault_eval
  import va_xlate_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [1:0]        acc,
  input  logic [PERM_W-1:0] perm,
  output logic [PERM_W-1:0] missing,
  output fault_e            perm_code
);

  logic [PERM_W-1:0] need;
  logic [PERM_W-1:0] have;

  assign need      = required_mask(mode, acc);
  assign have      = grant_vector(perm);
  assign missing   = need & ~have;
  assign perm_code = classify_missing(missing);

endmodule

// File: rtl/xlate_resp_reg.sv
module xlate_resp_reg
  import va_xlate_pkg::*;
#(
  parameter int PA_W = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  fault_e          in_code,
  input  logic [PA_W-1:0] in_pa,
  input  logic [1:0]      in_kind,
  output logic            rsp_valid,
  output logic            rsp_pa_valid,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_fault,
  output logic [2:0]      rsp_fault_code,
  output logic [1:0]      rsp_kind
);

  logic is_fault;
  assign is_fault = (in_code != FC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_pa_valid   <= 1'b0;
      rsp_pa         <= '0;
      rsp_fault      <= 1'b0;
      rsp_fault_code <= 3'd0;
      rsp_kind       <= 2'd0;
    end else begin
      rsp_valid      <= in_valid;
      rsp_pa_valid   <= in_valid & ~is_fault;
      rsp_fault      <= in_valid & is_fault;
      rsp_pa         <= (in_valid && !is_fault) ? in_pa : '0;
      rsp_fault_code <= in_valid ? 3'(in_code) : 3'd0;
      rsp_kind       <= in_valid ? in_kind : 2'd0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_pa_valid, rsp_fault}) == 1); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_pa_valid && !rsp_fault); // R10
  AST_REQ_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> rsp_valid); // R10

endmodule

// File: rtl/va_xlate_front.sv
module va_xlate_front
  import va_xlate_pkg::*;
#(
  parameter int VA_W  = 43,
  parameter int PG_W  = 13,
  parameter int PA_W  = 44,
  parameter int SP_LO = 32,
  localparam int VPN_W = VA_W - PG_W,
  localparam int PFN_W = PA_W - PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_va,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_mode,
  input  logic [1:0]        sp_enable,
  output logic              tlb_req,
  output logic [VPN_W-1:0]  tlb_vpn,
  input  logic              tlb_hit,
  input  logic [PFN_W-1:0]  tlb_pfn,
  input  logic [PERM_W-1:0] tlb_perm,
  output logic              rsp_valid,
  output logic              rsp_pa_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_fault,
  output logic [2:0]        rsp_fault_code,
  output logic [1:0]        rsp_kind
);

  logic              canonical;
  logic              sp_large_hit;
  logic              sp_small_hit;
  logic              sp_hit;
  logic [PA_W-1:0]   sp_pa;
  logic [PERM_W-1:0] perm_missing;
  fault_e            perm_code;
  fault_e            next_code;
  logic [PA_W-1:0]   next_pa;
  logic [PA_W-1:0]   tlb_pa;

  va_region_decode #(.VA_W(VA_W), .PA_W(PA_W), .SP_LO(SP_LO)) region_i (
    .va           (req_va),
    .sp_enable    (sp_enable),
    .canonical    (canonical),
    .sp_large_hit (sp_large_hit),
    .sp_small_hit (sp_small_hit),
    .sp_pa        (sp_pa)
  );

  perm_fault_eval perm_i (
    .mode      (req_mode),
    .acc       (req_acc),
    .perm      (tlb_perm),
    .missing   (perm_missing),
    .perm_code (perm_code)
  );

  assign sp_hit  = sp_large_hit | sp_small_hit;
  assign tlb_vpn = req_va[VA_W-1:PG_W];
  assign tlb_req = req_valid & canonical & ~sp_hit;
  assign tlb_pa  = {tlb_pfn, req_va[PG_W-1:0]};

  always_comb begin
    next_pa = '0;
    if (!canonical) begin
      next_code = FC_BVA;
    end else if (sp_hit) begin
      next_code = (req_mode == MODE_KERNEL) ? FC_NONE : FC_ACV;
      next_pa   = sp_pa;
    end else if (!tlb_hit) begin
      next_code = FC_TBM;
    end else begin
      next_code = perm_code;
      next_pa   = tlb_pa;
    end
  end

  xlate_resp_reg #(.PA_W(PA_W)) resp_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (req_valid),
    .in_code        (next_code),
    .in_pa          (next_pa),
    .in_kind        (kind_tag(req_acc)),
    .rsp_valid      (rsp_valid),
    .rsp_pa_valid   (rsp_pa_valid),
    .rsp_pa         (rsp_pa),
    .rsp_fault      (rsp_fault),
    .rsp_fault_code (rsp_fault_code),
    .rsp_kind       (rsp_kind)
  );

  AST_BAD_VA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !canonical |=> rsp_fault_code == 3'(FC_BVA)); // R1
  AST_SP_KERNEL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && canonical && sp_hit && req_mode == MODE_KERNEL |=> rsp_pa_valid); // R2
  AST_SP_USER_ACV: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && canonical && sp_hit && req_mode != MODE_KERNEL |=> rsp_fault_code == 3'(FC_ACV)); // R4
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req && !tlb_hit |=> rsp_fault_code == 3'(FC_TBM)); // R5
  AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req && tlb_hit && perm_missing == '0 |=> rsp_pa_valid); // R6
  AST_KIND_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_acc == ACC_EX |=> rsp_kind == 2'd2); // R9

endmodule

// File: tb/va_xlate_front_tb.sv
module va_xlate_front_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_va;
  logic [1:0]  req_acc;
  logic [1:0]  req_mode;
  logic [1:0]  sp_enable;
  logic        tlb_req;
  logic [29:0] tlb_vpn;
  logic        tlb_hit;
  logic [30:0] tlb_pfn;
  logic [11:0] tlb_perm;
  logic        rsp_valid;
  logic        rsp_pa_valid;
  logic [43:0] rsp_pa;
  logic        rsp_fault;
  logic [2:0]  rsp_fault_code;
  logic [1:0]  rsp_kind;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  va_xlate_front dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_acc(req_acc), .req_mode(req_mode), .sp_enable(sp_enable),
    .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit),
    .tlb_pfn(tlb_pfn), .tlb_perm(tlb_perm), .rsp_valid(rsp_valid),
    .rsp_pa_valid(rsp_pa_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code), .rsp_kind(rsp_kind)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_perm(input logic v, input logic fr, input logic fw,
                                          input logic fe, input logic [3:0] re,
                                          input logic [3:0] we);
    return {we, re, fe, fw, fr, v};
  endfunction

  // Expected code for a hit, written from the requirement text.
  function automatic logic [2:0] exp_hit_code(input logic [1:0] mode, input logic [1:0] acc,
                                              input logic [11:0] p);
    logic en, fo;
    en = (acc == 2'd1) ? p[8 + mode] : p[4 + mode];
    fo = (acc == 2'd1) ? p[2] : (acc == 2'd2) ? p[3] : p[1];
    if (!en) return 3'd2;
    if (fo) return 3'd3;
    if (!p[0]) return 3'd5;
    return 3'd0;
  endfunction

  // Drive one request; check lookup strobe before the edge, response after it.
  task automatic issue(input string tag, input logic [63:0] va, input logic [1:0] acc,
                       input logic [1:0] mode, input logic [1:0] spe, input logic hit,
                       input logic [30:0] pfn, input logic [11:0] perm,
                       input logic exp_lookup, input logic [2:0] exp_code,
                       input logic [43:0] exp_pa);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_mode = mode;
    sp_enable = spe; tlb_hit = hit; tlb_pfn = pfn; tlb_perm = perm;
    #1;
    chk({tag, " tlb_req"}, 64'(tlb_req), 64'(exp_lookup));
    if (exp_lookup) chk({tag, " tlb_vpn"}, 64'(tlb_vpn), 64'(va[42:13]));
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk({tag, " R10 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " code"}, 64'(rsp_fault_code), 64'(exp_code));
    chk({tag, " R10 fault"}, 64'(rsp_fault), 64'(exp_code != 3'd0));
    chk({tag, " R10 pa_valid"}, 64'(rsp_pa_valid), 64'(exp_code == 3'd0));
    chk({tag, " pa"}, 64'(rsp_pa), 64'(exp_code == 3'd0 ? exp_pa : 44'd0));
    chk({tag, " R9 kind"}, 64'(rsp_kind), 64'(acc == 2'd2 ? 2'd2 : acc == 2'd1 ? 2'd1 : 2'd0));
  endtask

  task automatic t_reset();
    chk("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10 reset pa_valid", 64'(rsp_pa_valid), 64'd0);
    chk("R10 reset fault", 64'(rsp_fault), 64'd0);
    chk("R10 reset pa", 64'(rsp_pa), 64'd0);
    chk("R10 reset code", 64'(rsp_fault_code), 64'd0);
  endtask

  task automatic t_canonical();
    logic [11:0] all_ok;
    all_ok = mk_perm(1, 0, 0, 0, 4'hF, 4'hF);
    issue("R1 upper ones-break", 64'h7FFF_FC00_0000_0000, 2'd0, 2'd0, 2'b11, 1, 31'h5, all_ok, 0, 3'd1, 0);
    issue("R1 stray bit 42", 64'h0000_0400_0000_0000, 2'd1, 2'd3, 2'b00, 0, 31'h0, 12'h0, 0, 3'd1, 0);
    issue("R1 stray bit 63", 64'h8000_0000_0000_1000, 2'd2, 2'd0, 2'b01, 1, 31'h1, all_ok, 0, 3'd1, 0);
    issue("R1 all ones ok", 64'hFFFF_FFFF_FFFF_E000, 2'd0, 2'd0, 2'b00, 1, 31'h12, all_ok, 1, 3'd0, {31'h12, 13'h0});
  endtask

  task automatic t_superpage();
    logic [63:0] va_l, va_s;
    va_l = 64'hFFFF_FC12_3456_789A;   // bits [42:41] = 10
    va_s = 64'hFFFF_FFFE_89AB_CDEF;   // bits [44:32] = 1FFE
    issue("R2 large window", va_l, 2'd0, 2'd0, 2'b01, 0, 31'h0, 12'h0, 0, 3'd0, 44'(va_l[40:0]));
    issue("R2 large window exec", va_l, 2'd2, 2'd0, 2'b11, 0, 31'h0, 12'h0, 0, 3'd0, 44'(va_l[40:0]));
    issue("R3 small window", va_s, 2'd1, 2'd0, 2'b10, 0, 31'h0, 12'h0, 0, 3'd0, 44'(va_s[31:0]));
    issue("R4 large window user", va_l, 2'd0, 2'd3, 2'b01, 1, 31'h7, 12'hFFF, 0, 3'd2, 0);
    issue("R4 small window exec mode", va_s, 2'd1, 2'd1, 2'b10, 1, 31'h7, 12'hFFF, 0, 3'd2, 0);
    issue("R11 large disabled", va_l, 2'd0, 2'd0, 2'b10, 0, 31'h0, 12'h0, 1, 3'd4, 0);
    issue("R11 small disabled", va_s, 2'd0, 2'd3, 2'b01, 1, 31'h33,
          mk_perm(1, 0, 0, 0, 4'h8, 4'h0), 1, 3'd0, {31'h33, va_s[12:0]});
  endtask

  task automatic t_lookup();
    issue("R5 miss", 64'h0000_0012_3456_7000, 2'd0, 2'd0, 2'b11, 0, 31'h1, 12'hFFF, 1, 3'd4, 0);
    issue("R5 miss user write", 64'h0000_0001_0000_0ABC, 2'd1, 2'd3, 2'b00, 0, 31'h0, 12'h0, 1, 3'd4, 0);
    issue("R6 hit read", 64'h0000_0000_0040_1234, 2'd0, 2'd2, 2'b11, 1, 31'h7ABC_DEF0,
          mk_perm(1, 0, 0, 0, 4'h4, 4'h0), 1, 3'd0, {31'h7ABC_DEF0, 13'h1234});
    issue("R6 hit write", 64'h0000_01FF_FFFF_FFFF, 2'd1, 2'd1, 2'b00, 1, 31'h1,
          mk_perm(1, 1, 0, 1, 4'h0, 4'h2), 1, 3'd0, {31'h1, 13'h1FFF});
  endtask

  task automatic t_perm();
    logic [63:0] va;
    va = 64'h0000_0000_0080_0010;
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 6; c++) begin
          logic [11:0] p;
          case (c)
            0: p = mk_perm(1, 0, 0, 0, 4'hF, 4'hF);
            1: p = mk_perm(0, 1, 1, 1, 4'h0, 4'h0);  // R8 everything missing
            2: p = mk_perm(0, 1, 1, 1, 4'hF, 4'hF);  // R8 fault-on over not-valid
            3: p = mk_perm(0, 0, 0, 0, 4'hF, 4'hF);  // R8 only valid missing
            4: p = mk_perm(1, 0, 0, 0, 4'hF, 4'h0);  // R7 read enables only
            default: p = mk_perm(1, 1, 0, 1, 4'h0, 4'hF); // R7 write enables only
          endcase
          issue("R7 R8 perm", va, 2'(a), 2'(m), 2'b00, 1, 31'h2A, p, 1,
                exp_hit_code(2'(m), 2'(a), p), {31'h2A, 13'h0010});
        end
      end
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_va = 64'h0000_0000_0000_2000; req_acc = 2'd0; req_mode = 2'd0;
    sp_enable = 2'b00; tlb_hit = 1'b0;
    @(negedge clk);
    req_va = 64'h0000_0000_0000_4000; tlb_hit = 1'b1; tlb_pfn = 31'h9;
    tlb_perm = mk_perm(1, 0, 0, 0, 4'h1, 4'h0);
    chk("R10 b2b first code", 64'(rsp_fault_code), 64'd4);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 b2b second pa", 64'(rsp_pa), 64'({31'h9, 13'h0}));
    chk("R10 b2b second valid", 64'(rsp_pa_valid), 64'd1);
    @(negedge clk);
    chk("R10 idle after", 64'(rsp_valid), 64'd0);
    chk("R10 idle no fault", 64'(rsp_fault), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_acc = '0; req_mode = '0;
    sp_enable = '0; tlb_hit = 1'b0; tlb_pfn = '0; tlb_perm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_canonical();
    t_superpage();
    t_lookup();
    t_perm();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule